// File: doc/BRIEF.md
# Conversion Start and Auto-Sleep Sequencer

This block sequences one successive-approximation conversion cycle from a single asynchronous start strobe. A high-to-low transition on the strobe freezes the sampled input (hold), raises busy and runs a conversion interval of fixed length. When that interval ends, busy and hold drop. A one-cycle load pulse copies the supplied result word into the output register. The bit-decision logic is not modelled: the conversion is a timed interval and the result comes in on a port.

The operating mode is chosen by the level of the strobe at the end of a conversion. If the strobe is high, the block stays awake and waits for the next falling edge. If the strobe is low, the block powers down. From power-down, a rising edge starts a wake-up interval. A falling edge that arrives during wake-up is remembered, and the conversion starts as soon as wake-up ends. If the strobe is still high when wake-up ends, the block waits awake for the falling edge.

Every interval is given in nanoseconds and turned into system-clock cycles from a clock-frequency parameter. Both are rounded up.

Top module: `cvs_sequencer`

## Requirements
- R1: While reset is asserted, busy_o, hold_o, pdn_o and load_o are all low.
- R2: When the block is awake and idle, a falling edge on start_i sets busy_o and hold_o high on the third rising clock edge after start_i changes. The strobe passes through two synchronizer flops and one state register.
- R3: busy_o and hold_o stay high for exactly CONV_CYC cycles, where CONV_CYC = ceil(CONV_NS × CLK_FREQ_HZ / 1e9). This is 1000 cycles at the defaults.
- R4: On the edge where busy_o falls, load_o goes high for exactly one cycle and result_o takes the value of result_i.
- R5: If start_i is high when the conversion ends, pdn_o stays low. If start_i is low when the conversion ends, pdn_o goes high on the same edge on which busy_o falls.
- R6: In power-down, a rising edge on start_i clears pdn_o on the third rising clock edge after the change, and a wake-up interval of WAKE_CYC cycles begins. WAKE_CYC is computed the same way from WAKE_NS, and is 1000 cycles at the defaults.
- R7: A falling edge on start_i during wake-up is latched. busy_o and hold_o stay low until wake-up ends, then rise exactly WAKE_CYC cycles after pdn_o fell.
- R8: If start_i is still high when wake-up ends, no conversion starts and pdn_o stays low. A later falling edge then starts a conversion with the timing of R2.
- R9: Edges on start_i while busy_o is high have no effect. The conversion ends at its scheduled cycle with a single load pulse, and no further conversion follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Asynchronous conversion-start strobe; its falling edge requests a sample |
| result_i | input | RES_W | Result word supplied by the abstracted conversion logic |
| busy_o | output | 1 | High while a conversion is in progress |
| hold_o | output | 1 | Track/hold command: high = hold, low = track |
| pdn_o | output | 1 | High while the converter is powered down |
| load_o | output | 1 | One-cycle strobe marking a new word on result_o |
| result_o | output | RES_W | Output register holding the last result |

## Verification
Every response to the strobe counts from the clock edge after the bench changes start_i. A falling edge shows up on busy_o and hold_o on the third edge, and a rising edge out of power-down shows up on pdn_o on the third edge. Busy then lasts CONV_CYC edges, and the load pulse with the power-down entry shares the edge on which busy falls. In the deferred case, busy rises WAKE_CYC edges after pdn_o falls. The bench drives and samples only on falling clock edges. It steps an exact number of edges for each check, one cycle before and one cycle at each expected transition, so an off-by-one in any timer or synchronizer shows up as a mismatch.

// File: rtl/cvs_pkg.sv
`timescale 1ns/1ps
package cvs_pkg;

  typedef enum logic [2:0] {
    ST_TRACK      = 3'd0,
    ST_CONV       = 3'd1,
    ST_SLEEP      = 3'd2,
    ST_WAKE       = 3'd3,
    ST_WAKE_ARMED = 3'd4
  } cvs_state_e;

  // Round a duration in ns up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(longint unsigned freq_hz,
                                               longint unsigned dur_ns);
    longint unsigned prod;
    prod = freq_hz * dur_ns + 64'd999_999_999;
    return int'(prod / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/cvs_sync_edge.sv
`timescale 1ns/1ps
module cvs_sync_edge #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RESET_VAL;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_VAL;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

endmodule

// File: rtl/cvs_interval_timer.sv
`timescale 1ns/1ps
module cvs_interval_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = load | (cnt_q != '0);
    cnt_nxt = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/cvs_seq_fsm.sv
`timescale 1ns/1ps
module cvs_seq_fsm
  import cvs_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned CONV_CYC = 1000,
  parameter int unsigned WAKE_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_level,
  input  logic             strb_rise,
  input  logic             strb_fall,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             conv_end,
  output cvs_state_e       state
);

  localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC - 1);

  cvs_state_e state_q, state_nxt;

  always_comb begin
    state_nxt = state_q;
    tmr_load  = 1'b0;
    tmr_val   = CONV_LD;
    conv_end  = 1'b0;
    unique case (state_q)
      ST_TRACK: begin
        if (strb_fall) begin
          state_nxt = ST_CONV;
          tmr_load  = 1'b1;
        end
      end
      ST_CONV: begin
        if (tmr_done) begin
          conv_end  = 1'b1;
          state_nxt = strb_level ? ST_TRACK : ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (strb_rise) begin
          state_nxt = ST_WAKE;
          tmr_load  = 1'b1;
          tmr_val   = WAKE_LD;
        end
      end
      ST_WAKE: begin
        if (tmr_done) begin
          if (strb_fall || !strb_level) begin
            state_nxt = ST_CONV;
            tmr_load  = 1'b1;
          end else begin
            state_nxt = ST_TRACK;
          end
        end else if (strb_fall) begin
          state_nxt = ST_WAKE_ARMED;
        end
      end
      ST_WAKE_ARMED: begin
        if (tmr_done) begin
          state_nxt = ST_CONV;
          tmr_load  = 1'b1;
        end
      end
      default: state_nxt = ST_TRACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TRACK;
    else        state_q <= state_nxt;
  end

  assign state = state_q;

endmodule

// File: rtl/cvs_sequencer.sv
`timescale 1ns/1ps
module cvs_sequencer
  import cvs_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned CONV_NS     = 5000,
  parameter int unsigned WAKE_NS     = 5000,
  parameter int unsigned RES_W       = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [RES_W-1:0] result_i,
  output logic             busy_o,
  output logic             hold_o,
  output logic             pdn_o,
  output logic             load_o,
  output logic [RES_W-1:0] result_o
);

  localparam int unsigned CONV_CYC = ns_to_cycles(CLK_FREQ_HZ, CONV_NS);
  localparam int unsigned WAKE_CYC = ns_to_cycles(CLK_FREQ_HZ, WAKE_NS);
  localparam int unsigned MAX_CYC  = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             s_level, s_rise, s_fall;
  logic             tmr_load, tmr_done, conv_end;
  logic [CNT_W-1:0] tmr_val;
  cvs_state_e       state;

  cvs_sync_edge #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (start_i),
    .level (s_level),
    .rise  (s_rise),
    .fall  (s_fall)
  );

  cvs_interval_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  cvs_seq_fsm #(
    .CNT_W    (CNT_W),
    .CONV_CYC (CONV_CYC),
    .WAKE_CYC (WAKE_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .strb_level (s_level),
    .strb_rise  (s_rise),
    .strb_fall  (s_fall),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .conv_end   (conv_end),
    .state      (state)
  );

  // Output register and load strobe
  logic             load_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) load_q <= 1'b0;
    else            load_q <= conv_end;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    res_q <= '0;
    else if (conv_end) res_q <= result_i;
  end

  assign busy_o   = (state == ST_CONV);
  assign hold_o   = (state == ST_CONV);
  assign pdn_o    = (state == ST_SLEEP);
  assign load_o   = load_q;
  assign result_o = res_q;

endmodule

// File: rtl/cvs_sequencer_chk.sv
`timescale 1ns/1ps
module cvs_sequencer_chk
  import cvs_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned CONV_NS     = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic hold_o,
  input logic pdn_o,
  input logic load_o
);

  localparam int unsigned CONV_CYC = ns_to_cycles(CLK_FREQ_HZ, CONV_NS);

  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!busy_o && !hold_o && !pdn_o && !load_o);
    end
  end

  a_r2_hold_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> hold_o);

  a_r3_conv_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> busy_cnt < CONV_CYC);

  a_r3_conv_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_cnt == CONV_CYC);

  a_r4_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  a_r4_load_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> ($past(busy_o) && !busy_o));

  a_r5_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdn_o) |-> load_o);

  a_r5_no_busy_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_o |-> !busy_o);

  a_r7_awake_before_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(pdn_o));

endmodule

bind cvs_sequencer cvs_sequencer_chk #(
  .CLK_FREQ_HZ (CLK_FREQ_HZ),
  .CONV_NS     (CONV_NS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy_o (busy_o),
  .hold_o (hold_o),
  .pdn_o  (pdn_o),
  .load_o (load_o)
);

// File: tb/tb_cvs_sequencer.sv
`timescale 1ns/1ps
module tb_cvs_sequencer;

  localparam int CLK_MHZ  = 200;
  localparam int CONV_NS  = 5000;
  localparam int WAKE_NS  = 5000;
  localparam int CONV_CYC = CLK_MHZ * CONV_NS / 1000;
  localparam int WAKE_CYC = CLK_MHZ * WAKE_NS / 1000;
  localparam int RES_W    = 14;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [RES_W-1:0] result_i;
  logic             busy_o, hold_o, pdn_o, load_o;
  logic [RES_W-1:0] result_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cvs_sequencer #(
    .CLK_FREQ_HZ (CLK_MHZ * 1_000_000),
    .CONV_NS     (CONV_NS),
    .WAKE_NS     (WAKE_NS),
    .RES_W       (RES_W)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .result_i (result_i),
    .busy_o   (busy_o),
    .hold_o   (hold_o),
    .pdn_o    (pdn_o),
    .load_o   (load_o),
    .result_o (result_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 1'b1; result_i = '0;
    step(4);
    chk("R1", "busy in reset", busy_o, 0);
    chk("R1", "hold in reset", hold_o, 0);
    chk("R1", "pdn in reset",  pdn_o,  0);
    chk("R1", "load in reset", load_o, 0);
    rst_n = 1'b1;
    step(6);
  endtask

  // Conversion with strobe back high before the end (stays awake)
  task automatic t_awake_conv(input logic [RES_W-1:0] val);
    result_i = val;
    start_i  = 1'b0;
    step(2);
    chk("R2", "busy before sync", busy_o, 0);
    step(1);
    chk("R2", "busy after fall", busy_o, 1);
    chk("R2", "hold after fall", hold_o, 1);
    step(5); start_i = 1'b1;
    step(CONV_CYC - 1 - 5);
    chk("R3", "busy last cycle", busy_o, 1);
    step(1);
    chk("R3", "busy after interval", busy_o, 0);
    chk("R4", "load at end", load_o, 1);
    chk("R4", "result", result_o, val);
    chk("R5", "pdn stays low", pdn_o, 0);
    step(1);
    chk("R4", "load single", load_o, 0);
    step(10);
  endtask

  // R9: strobe toggles while converting
  task automatic t_ignore(input logic [RES_W-1:0] val);
    result_i = val;
    start_i  = 1'b0;
    step(3);
    chk("R9", "busy up", busy_o, 1);
    for (int k = 0; k < 5; k++) begin
      step(50);
      start_i = ~start_i;
    end
    step(CONV_CYC - 1 - 250);
    chk("R9", "busy still high", busy_o, 1);
    step(1);
    chk("R9", "busy ends on schedule", busy_o, 0);
    chk("R9", "load once", load_o, 1);
    chk("R9", "result", result_o, val);
    step(1);
    chk("R9", "load not repeated", load_o, 0);
    step(20);
    chk("R9", "no extra conversion", busy_o, 0);
  endtask

  // Strobe held low through the end: power-down
  task automatic t_enter_sleep(input logic [RES_W-1:0] val);
    result_i = val;
    start_i  = 1'b0;
    step(3 + CONV_CYC - 1);
    chk("R5", "awake before end", pdn_o, 0);
    step(1);
    chk("R5", "pdn at end", pdn_o, 1);
    chk("R5", "busy low", busy_o, 0);
    chk("R4", "result", result_o, val);
    step(10);
  endtask

  // Short strobe from power-down: conversion deferred to end of wake
  task automatic t_short_wake(input logic [RES_W-1:0] val);
    result_i = val;
    start_i  = 1'b1;
    step(2);
    chk("R6", "still asleep", pdn_o, 1);
    step(1);
    chk("R6", "waking", pdn_o, 0);
    step(10);
    start_i = 1'b0;
    step(WAKE_CYC - 11);
    chk("R7", "busy deferred", busy_o, 0);
    chk("R7", "hold deferred", hold_o, 0);
    step(1);
    chk("R7", "busy at wake end", busy_o, 1);
    chk("R7", "hold at wake end", hold_o, 1);
    step(CONV_CYC);
    chk("R7", "busy done", busy_o, 0);
    chk("R5", "back asleep", pdn_o, 1);
    chk("R4", "result", result_o, val);
    step(10);
  endtask

  // Long strobe from power-down: waits awake for the falling edge
  task automatic t_long_wake(input logic [RES_W-1:0] val);
    result_i = val;
    start_i  = 1'b1;
    step(3 + WAKE_CYC + 20);
    chk("R8", "no conversion", busy_o, 0);
    chk("R8", "awake", pdn_o, 0);
    start_i = 1'b0;
    step(2);
    chk("R8", "busy before sync", busy_o, 0);
    step(1);
    chk("R8", "busy after fall", busy_o, 1);
    step(CONV_CYC);
    chk("R8", "busy done", busy_o, 0);
    chk("R8", "result", result_o, val);
    chk("R5", "asleep", pdn_o, 1);
    step(10);
  endtask

  initial begin
    t_reset();
    t_awake_conv(14'h2A5B);
    t_ignore(14'h1234);
    t_awake_conv(14'h0000);
    t_enter_sleep(14'h3FFF);
    t_short_wake(14'h0001);
    t_long_wake(14'h2000);
    t_short_wake(14'h1555);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule